// File: doc/BRIEF.md
# Byte-Port Packet Network Controller

This block is a small network controller on a synchronous register bus. Software moves whole Ethernet frames through it one byte per bus access. A single receive buffer and a single transmit buffer each hold a frame. Received frames arrive on a byte stream that carries valid and last but no ready. Frames that software has finished writing leave on a byte stream with valid, ready and last.

One shared busy flag tracks the interrupt state. When a frame is stored, or a transmit completes, a done bit in the interrupt control register is set, the level interrupt rises and busy goes high. Busy stays high until software writes to interrupt control and no done bit remains set. While busy is high, incoming frames are discarded whole. A self-test write performs a soft reset of counts, pointers and flags, then leaves the self-test bit set so that software can confirm the interrupt path.

Top module: `nic_byteport`

## Requirements
- R1: After reset, busy (offset 0x08, bit 0) reads 1. Receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0. The interrupt output is low.
- R2: The bus address is 6 bits wide and read data is valid in the cycle after the read strobe. Offset 0x00 reads 32'h5350494D and offset 0x04 reads 32'h3054454E. Offsets 0x18 and 0x20, and all unmapped offsets, read 0. Writes to read-only or unmapped offsets have no effect.
- R3: The interrupt output is high exactly when at least one of interrupt control bit 0 (transmit done), bit 1 (receive done) or bit 31 (self-test) is set.
- R4: A frame is stored only if busy is 0 and the receive count is below FRAME_MAX when its first byte arrives. A stored frame loads the receive count with its length, restarts the read position, sets receive done and sets busy. Frames that arrive while busy is 1 are discarded without any effect on counts or flags.
- R5: A frame of FRAME_MAX (1514) bytes or more is discarded and leaves the receive count, interrupt control and busy unchanged. A frame of FRAME_MAX-1 bytes is stored.
- R6: A read of the receive data port (0x1C) while the receive count is nonzero returns the next stored byte in arrival order in bits 7:0 and decrements the count. When the count is 0, the read returns 0 and the count stays 0.
- R7: A read of interrupt control returns its current value, and the self-test bit is then cleared.
- R8: A write to interrupt control acts on a single bit, chosen in this priority: bit 0 clears transmit done; otherwise bit 1 clears receive done; otherwise bit 31 triggers the self-test. A write of zero changes no bit. After the write, busy equals 1 if any interrupt control bit is still set and 0 otherwise.
- R9: A self-test write sets the receive count, the transmit count and both buffer positions to 0, clears the done bits, and sets the self-test bit, which leaves busy at 1.
- R10: A write to the transmit count (0x10) loads the value if it is at most FRAME_MAX and loads 0 otherwise. The same write restarts the transmit write position.
- R11: Each write to the transmit data port (0x20) stores bits 7:0 of the write. When the number of stored bytes equals the transmit count, or reaches FRAME_MAX, the frame is sent. Sending clears the transmit count, sets transmit done and sets busy. The egress stream then presents the bytes in order, asserts last on the final byte, and holds each byte while ready is low.
- R12: Transmit data port writes made while a frame is still leaving on the egress stream are ignored: they store nothing, start no frame and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 6 | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Ingress byte valid |
| rx_data | input | 8 | Ingress byte |
| rx_last | input | 1 | Marks the final byte of an ingress frame |
| tx_valid | output | 1 | Egress byte valid |
| tx_data | output | 8 | Egress byte |
| tx_last | output | 1 | Marks the final byte of an egress frame |
| tx_ready | input | 1 | Egress sink accepts the byte |

## Verification
Most wrong internal state becomes visible at the ports within one or two bus accesses. A wrong receive count or read position causes the next data-port read to return a byte out of order, or a nonzero value after the count has reached zero. A wrong interrupt control value appears as a mismatch between irq and busy right after the next write to interrupt control. A transmit position that is off by one either sends the frame one write early or late, or produces a missing or extra last on the egress stream. That shows as soon as the frame drains, and for frames that fill the buffer only after 1514 writes.

// File: rtl/nic_pkg.sv
package nic_pkg;

  // Register byte offsets within the 6-bit decoded window
  localparam logic [5:0] OFS_ID0    = 6'h00;
  localparam logic [5:0] OFS_ID1    = 6'h04;
  localparam logic [5:0] OFS_BUSY   = 6'h08;
  localparam logic [5:0] OFS_RXCNT  = 6'h0C;
  localparam logic [5:0] OFS_TXCNT  = 6'h10;
  localparam logic [5:0] OFS_ICTL   = 6'h14;
  localparam logic [5:0] OFS_IINFO  = 6'h18;
  localparam logic [5:0] OFS_RXPORT = 6'h1C;
  localparam logic [5:0] OFS_TXPORT = 6'h20;

  // Interrupt control bit positions
  localparam int ICTL_TXDONE_BIT   = 0;
  localparam int ICTL_RXDONE_BIT   = 1;
  localparam int ICTL_SELFTEST_BIT = 31;

  typedef struct packed {
    logic selftest;
    logic rxdone;
    logic txdone;
  } ictl_t;

  typedef enum logic [1:0] {RX_IDLE, RX_TAKE, RX_DROP} rx_st_t;
  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SHOW} tx_st_t;

endpackage

// File: rtl/nic_frame_ram.sv
module nic_frame_ram #(
  parameter int DEPTH = 1514,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with enable; the output holds between reads
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/nic_rx_capture.sv
module nic_rx_capture
  import nic_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  parameter int AW        = $clog2(FRAME_MAX),
  parameter int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          srst,
  input  logic          can_accept,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic          commit,
  output logic [CW-1:0] commit_len
);

  localparam logic [CW-1:0] LAST_SLOT = CW'(FRAME_MAX - 1);

  rx_st_t        state;
  logic [CW-1:0] byte_idx;
  logic          taking;
  logic          fits;
  logic          mid_after;

  assign taking     = rx_valid && (state == RX_TAKE || (state == RX_IDLE && can_accept));
  assign fits       = (byte_idx != LAST_SLOT);
  assign ram_we     = taking && fits && !srst;
  assign ram_waddr  = byte_idx[AW-1:0];
  assign ram_wdata  = rx_data;
  assign commit     = taking && fits && rx_last && !srst;
  assign commit_len = byte_idx + CW'(1);
  // A frame is still in flight after this cycle
  assign mid_after  = (state != RX_IDLE || rx_valid) && !(rx_valid && rx_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      byte_idx <= '0;
    end else if (srst) begin
      state    <= mid_after ? RX_DROP : RX_IDLE;
      byte_idx <= '0;
    end else if (rx_valid) begin
      case (state)
        RX_IDLE: begin
          if (can_accept) begin
            if (rx_last) begin
              byte_idx <= '0;
            end else begin
              state    <= RX_TAKE;
              byte_idx <= CW'(1);
            end
          end else if (!rx_last) begin
            state <= RX_DROP;
          end
        end
        RX_TAKE: begin
          if (!fits) begin
            state    <= rx_last ? RX_IDLE : RX_DROP;
            byte_idx <= '0;
          end else if (rx_last) begin
            state    <= RX_IDLE;
            byte_idx <= '0;
          end else begin
            byte_idx <= byte_idx + CW'(1);
          end
        end
        RX_DROP: begin
          if (rx_last) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R4: a frame refused at its first byte never commits in that cycle
  a_r4_refused_start: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && rx_valid && !can_accept) |-> !commit);

  // R5: a committed length always stays below the frame limit
  a_r5_commit_len: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_len < CW'(FRAME_MAX)));

endmodule

// File: rtl/nic_tx_stream.sv
module nic_tx_stream
  import nic_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  parameter int AW        = $clog2(FRAME_MAX),
  parameter int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          launch,
  input  logic [CW-1:0] launch_len,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [7:0]    ram_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          active
);

  tx_st_t        state;
  logic [CW-1:0] idx;
  logic [CW-1:0] len;

  assign ram_re    = (state == TX_LOAD);
  assign ram_raddr = idx[AW-1:0];
  assign tx_valid  = (state == TX_SHOW);
  assign tx_data   = ram_rdata;
  assign tx_last   = (idx == len - CW'(1));
  assign active    = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state <= TX_IDLE;
      idx   <= '0;
      len   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (launch) begin
            len   <= launch_len;
            idx   <= '0;
            state <= TX_LOAD;
          end
        end
        TX_LOAD: state <= TX_SHOW;
        TX_SHOW: begin
          if (tx_ready) begin
            if (tx_last) begin
              state <= TX_IDLE;
            end else begin
              idx   <= idx + CW'(1);
              state <= TX_LOAD;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R11: a byte that is not taken stays on the stream unchanged
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R12: no new frame may start while one is leaving
  a_r12_launch_idle: assert property (@(posedge clk) disable iff (rst)
    launch |-> (state == TX_IDLE));

endmodule

// File: rtl/nic_byteport.sv
module nic_byteport
  import nic_pkg::*;
#(
  parameter int          FRAME_MAX = 1514,
  parameter logic [31:0] ID_WORD0  = 32'h5350_494D,
  parameter logic [31:0] ID_WORD1  = 32'h3054_454E
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);

  localparam int AW = $clog2(FRAME_MAX);
  localparam int CW = $clog2(FRAME_MAX + 1);
  localparam logic [CW-1:0] FMAX_C = CW'(FRAME_MAX);

  // Architectural state
  logic          busy_q;
  logic [CW-1:0] rx_cnt_q;
  logic [AW-1:0] rx_rptr_q;
  logic [CW-1:0] tx_cnt_q;
  logic [CW-1:0] tx_wptr_q;
  ictl_t         ic_q;
  logic          irq_q;
  logic [31:0]   rdata_q;
  logic          sel_ram_q;

  // Next-state values
  logic          n_busy;
  logic [CW-1:0] n_rxc;
  logic [AW-1:0] n_rxp;
  logic [CW-1:0] n_txc;
  logic [CW-1:0] n_txp;
  ictl_t         n_ic;
  logic          srst;
  logic          launch;
  logic          txram_we;

  // Bus decode
  logic rd_ictl, rd_rxport, wr_ictl, wr_txcnt, wr_txport;
  assign rd_ictl   = bus_rd && (bus_addr == OFS_ICTL);
  assign rd_rxport = bus_rd && (bus_addr == OFS_RXPORT);
  assign wr_ictl   = bus_wr && (bus_addr == OFS_ICTL);
  assign wr_txcnt  = bus_wr && (bus_addr == OFS_TXCNT);
  assign wr_txport = bus_wr && (bus_addr == OFS_TXPORT);

  // Sub-block connections
  logic          can_accept;
  logic          rx_we;
  logic [AW-1:0] rx_waddr;
  logic [7:0]    rx_wbyte;
  logic          rx_commit;
  logic [CW-1:0] rx_commit_len;
  logic          rxram_re;
  logic [7:0]    rxram_q;
  logic          tx_active;
  logic          txram_re;
  logic [AW-1:0] txram_raddr;
  logic [7:0]    txram_q;
  logic [CW-1:0] wptr_inc;

  assign can_accept = !busy_q && (rx_cnt_q < FMAX_C);
  assign rxram_re   = rd_rxport && (rx_cnt_q != '0);
  assign wptr_inc   = tx_wptr_q + CW'(1);

  always_comb begin
    n_busy   = busy_q;
    n_rxc    = rx_cnt_q;
    n_rxp    = rx_rptr_q;
    n_txc    = tx_cnt_q;
    n_txp    = tx_wptr_q;
    n_ic     = ic_q;
    srst     = 1'b0;
    launch   = 1'b0;
    txram_we = 1'b0;

    // Read side effects
    if (rd_ictl) n_ic.selftest = 1'b0;
    if (rd_rxport && rx_cnt_q != '0) begin
      n_rxc = rx_cnt_q - CW'(1);
      n_rxp = rx_rptr_q + AW'(1);
    end

    // Write effects
    if (wr_txcnt) begin
      n_txc = (bus_wdata <= 32'(FRAME_MAX)) ? bus_wdata[CW-1:0] : '0;
      n_txp = '0;
    end

    if (wr_ictl) begin
      if (bus_wdata[ICTL_TXDONE_BIT]) begin
        n_ic.txdone = 1'b0;
      end else if (bus_wdata[ICTL_RXDONE_BIT]) begin
        n_ic.rxdone = 1'b0;
      end else if (bus_wdata[ICTL_SELFTEST_BIT]) begin
        srst  = 1'b1;
        n_rxc = '0;
        n_rxp = '0;
        n_txc = '0;
        n_txp = '0;
        n_ic  = '{selftest: 1'b1, rxdone: 1'b0, txdone: 1'b0};
      end
      n_busy = |n_ic;
    end

    if (wr_txport && !tx_active) begin
      txram_we = 1'b1;
      if (wptr_inc == FMAX_C || wptr_inc == tx_cnt_q) begin
        launch      = 1'b1;
        n_txc       = '0;
        n_txp       = '0;
        n_ic.txdone = 1'b1;
        n_busy      = 1'b1;
      end else begin
        n_txp = wptr_inc;
      end
    end

    // Frame arrival (already suppressed during a soft reset)
    if (rx_commit) begin
      n_rxc       = rx_commit_len;
      n_rxp       = '0;
      n_ic.rxdone = 1'b1;
      n_busy      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b1;
      rx_cnt_q  <= '0;
      rx_rptr_q <= '0;
      tx_cnt_q  <= '0;
      tx_wptr_q <= '0;
      ic_q      <= '0;
      irq_q     <= 1'b0;
    end else begin
      busy_q    <= n_busy;
      rx_cnt_q  <= n_rxc;
      rx_rptr_q <= n_rxp;
      tx_cnt_q  <= n_txc;
      tx_wptr_q <= n_txp;
      ic_q      <= n_ic;
      irq_q     <= |n_ic;
    end
  end

  // Read data path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      sel_ram_q <= 1'b0;
    end else if (bus_rd) begin
      sel_ram_q <= 1'b0;
      case (bus_addr)
        OFS_ID0:    rdata_q <= ID_WORD0;
        OFS_ID1:    rdata_q <= ID_WORD1;
        OFS_BUSY:   rdata_q <= {31'b0, busy_q};
        OFS_RXCNT:  rdata_q <= {{(32-CW){1'b0}}, rx_cnt_q};
        OFS_TXCNT:  rdata_q <= {{(32-CW){1'b0}}, tx_cnt_q};
        OFS_ICTL:   rdata_q <= {ic_q.selftest, 29'b0, ic_q.rxdone, ic_q.txdone};
        OFS_RXPORT: begin
          rdata_q   <= '0;
          sel_ram_q <= (rx_cnt_q != '0);
        end
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_ram_q ? {24'b0, rxram_q} : rdata_q;
  assign irq       = irq_q;

  nic_frame_ram #(.DEPTH(FRAME_MAX), .AW(AW)) u_rx_ram (
    .clk   (clk),
    .we    (rx_we),
    .waddr (rx_waddr),
    .wdata (rx_wbyte),
    .re    (rxram_re),
    .raddr (rx_rptr_q),
    .rdata (rxram_q)
  );

  nic_frame_ram #(.DEPTH(FRAME_MAX), .AW(AW)) u_tx_ram (
    .clk   (clk),
    .we    (txram_we),
    .waddr (tx_wptr_q[AW-1:0]),
    .wdata (bus_wdata[7:0]),
    .re    (txram_re),
    .raddr (txram_raddr),
    .rdata (txram_q)
  );

  nic_rx_capture #(.FRAME_MAX(FRAME_MAX), .AW(AW), .CW(CW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .srst       (srst),
    .can_accept (can_accept),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .ram_we     (rx_we),
    .ram_waddr  (rx_waddr),
    .ram_wdata  (rx_wbyte),
    .commit     (rx_commit),
    .commit_len (rx_commit_len)
  );

  nic_tx_stream #(.FRAME_MAX(FRAME_MAX), .AW(AW), .CW(CW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .abort      (srst),
    .launch     (launch),
    .launch_len (wptr_inc),
    .ram_re     (txram_re),
    .ram_raddr  (txram_raddr),
    .ram_rdata  (txram_q),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .active     (tx_active)
  );

  // R8: after an interrupt-control write, busy mirrors the interrupt level
  a_r8_busy_follows: assert property (@(posedge clk) disable iff (rst)
    wr_ictl |=> (busy_q == irq));

  // R5: the receive count never reaches the frame limit
  a_r5_rxcnt_bound: assert property (@(posedge clk) disable iff (rst)
    rx_cnt_q < FMAX_C);

  // R10: the transmit count never exceeds the frame limit
  a_r10_txcnt_bound: assert property (@(posedge clk) disable iff (rst)
    tx_cnt_q <= FMAX_C);

  // R7: a lone read of interrupt control leaves the self-test bit clear
  a_r7_selftest_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_ictl && !bus_wr) |=> !ic_q.selftest);

  // R11: a send raises transmit done and busy, and empties the count
  a_r11_send_flags: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy_q && ic_q.txdone && irq && tx_cnt_q == '0));

  // R6: reading an empty receive port leaves the count at zero
  a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_rxport && rx_cnt_q == '0 && !rx_commit) |=> (rx_cnt_q == '0));

endmodule

// File: tb/sim_nic_byteport.sv
module sim_nic_byteport;

  localparam int FMAX = 1514;
  localparam logic [31:0] ID0 = 32'h5350_494D;
  localparam logic [31:0] ID1 = 32'h3054_454E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        tx_ready = 1'b1;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nic_byteport u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  // Egress capture, sampled mid-cycle
  logic [7:0] cap_byte [2048];
  logic       cap_lastf [2048];
  int cap_n = 0;
  int last_n = 0;
  always @(negedge clk) begin
    if (tx_valid && tx_ready && cap_n < 2048) begin
      cap_byte[cap_n]  = tx_data;
      cap_lastf[cap_n] = tx_last;
      cap_n = cap_n + 1;
      if (tx_last) last_n = last_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec = nvec + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    do_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic send_frame(input int len, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = base + 8'(i);
      rx_last  = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #2 tx_ready = v;
  endtask

  // Vector: {op(1=read-check,0=write), req(4), addr(8), data(32)}
  localparam int NV = 30;
  localparam logic [44:0] VTAB [NV] = '{
    {1'b1, 4'd1,  8'h08, 32'd1},        // R1 busy after reset
    {1'b1, 4'd1,  8'h0C, 32'd0},        // R1
    {1'b1, 4'd1,  8'h10, 32'd0},        // R1
    {1'b1, 4'd1,  8'h14, 32'd0},        // R1
    {1'b1, 4'd6,  8'h1C, 32'd0},        // R6 empty port
    {1'b1, 4'd6,  8'h0C, 32'd0},        // R6 count untouched
    {1'b1, 4'd2,  8'h00, ID0},          // R2
    {1'b1, 4'd2,  8'h04, ID1},          // R2
    {1'b1, 4'd2,  8'h18, 32'd0},        // R2
    {1'b1, 4'd2,  8'h20, 32'd0},        // R2
    {1'b1, 4'd2,  8'h24, 32'd0},        // R2 unmapped
    {1'b1, 4'd2,  8'h3C, 32'd0},        // R2 unmapped
    {1'b0, 4'd2,  8'h00, 32'hFFFF_FFFF},// R2 write to read-only
    {1'b1, 4'd2,  8'h00, ID0},          // R2
    {1'b0, 4'd2,  8'h0C, 32'd77},       // R2 write to read-only count
    {1'b1, 4'd2,  8'h0C, 32'd0},        // R2
    {1'b0, 4'd10, 8'h10, 32'd100},      // R10
    {1'b1, 4'd10, 8'h10, 32'd100},      // R10
    {1'b0, 4'd10, 8'h10, 32'd1514},     // R10 limit accepted
    {1'b1, 4'd10, 8'h10, 32'd1514},     // R10
    {1'b0, 4'd10, 8'h10, 32'd1515},     // R10 over limit
    {1'b1, 4'd10, 8'h10, 32'd0},        // R10
    {1'b0, 4'd9,  8'h10, 32'd5},        // R9 preload
    {1'b0, 4'd9,  8'h14, 32'h8000_0000},// R9 self-test
    {1'b1, 4'd9,  8'h08, 32'd1},        // R9 busy held
    {1'b1, 4'd9,  8'h10, 32'd0},        // R9 count cleared
    {1'b1, 4'd7,  8'h14, 32'h8000_0000},// R7 first read
    {1'b1, 4'd7,  8'h14, 32'd0},        // R7 cleared after read
    {1'b0, 4'd8,  8'h14, 32'd0},        // R8 zero write
    {1'b1, 4'd8,  8'h08, 32'd0}         // R8 busy drops
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'b0, irq}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [44:0] e;
      string tag;
      e = VTAB[k];
      tag = $sformatf("R%0d vec%0d", e[43:40], k);
      if (e[44]) rd_check(tag, e[37:32], e[31:0]);
      else do_wr(e[37:32], e[31:0]);
    end

    // R3: interrupt level follows the self-test bit
    do_wr(6'h14, 32'h8000_0000);
    check("R3 irq set", {31'b0, irq}, 32'd1);
    rd_check("R7 readback", 6'h14, 32'h8000_0000);
    check("R3 irq clear", {31'b0, irq}, 32'd0);
    do_wr(6'h14, 32'd0);
    rd_check("R8 busy after zero write", 6'h08, 32'd0);

    // R4: frame stored when idle; second frame dropped while busy
    send_frame(5, 8'h10);
    rd_check("R4 rx count", 6'h0C, 32'd5);
    rd_check("R4 rxdone", 6'h14, 32'd2);
    check("R3 irq on rx", {31'b0, irq}, 32'd1);
    rd_check("R4 busy", 6'h08, 32'd1);
    send_frame(3, 8'h80);
    rd_check("R4 drop while busy", 6'h0C, 32'd5);
    rd_check("R6 byte0", 6'h1C, 32'h10);
    rd_check("R6 byte1", 6'h1C, 32'h11);
    rd_check("R6 count dec", 6'h0C, 32'd3);
    do_wr(6'h14, 32'd2);
    rd_check("R8 rx ack busy", 6'h08, 32'd0);
    check("R3 irq low", {31'b0, irq}, 32'd0);
    rd_check("R6 byte2", 6'h1C, 32'h12);
    rd_check("R6 byte3", 6'h1C, 32'h13);
    rd_check("R6 byte4", 6'h1C, 32'h14);
    rd_check("R6 empty read", 6'h1C, 32'd0);
    rd_check("R6 count stays 0", 6'h0C, 32'd0);

    // R5: size limits
    send_frame(FMAX, 8'h20);
    rd_check("R5 oversize count", 6'h0C, 32'd0);
    rd_check("R5 oversize flags", 6'h14, 32'd0);
    rd_check("R5 oversize busy", 6'h08, 32'd0);
    send_frame(FMAX - 1, 8'h30);
    rd_check("R5 max frame count", 6'h0C, 32'd1513);
    rd_check("R5 max frame byte0", 6'h1C, 32'h30);
    do_wr(6'h14, 32'd2);

    // R4: new frame replaces leftover bytes
    send_frame(2, 8'h70);
    rd_check("R4 replaced count", 6'h0C, 32'd2);
    rd_check("R4 replaced byte", 6'h1C, 32'h70);

    // R11: three-byte send
    base = cap_n;
    do_wr(6'h10, 32'd3);
    do_wr(6'h20, 32'h1C1);
    do_wr(6'h20, 32'hC2);
    rd_check("R11 not yet sent", 6'h14, 32'd2);
    do_wr(6'h20, 32'hC3);
    repeat (20) @(negedge clk);
    check("R11 byte count", 32'(cap_n - base), 32'd3);
    check("R11 b0", {24'b0, cap_byte[base]}, 32'hC1);
    check("R11 b2", {24'b0, cap_byte[base+2]}, 32'hC3);
    check("R11 last pos", {30'b0, cap_lastf[base+1], cap_lastf[base+2]}, 32'd1);
    rd_check("R11 flags", 6'h14, 32'd3);
    rd_check("R11 count cleared", 6'h10, 32'd0);

    // R8: priority of acknowledge bits
    do_wr(6'h14, 32'd3);
    rd_check("R8 bit0 first", 6'h14, 32'd2);
    rd_check("R8 busy kept", 6'h08, 32'd1);
    do_wr(6'h14, 32'h8000_0002);
    rd_check("R8 bit1 over bit31", 6'h14, 32'd0);
    rd_check("R8 busy clear", 6'h08, 32'd0);

    // R11 backpressure and R12 ignored writes
    set_ready(1'b0);
    base = cap_n;
    do_wr(6'h10, 32'd2);
    do_wr(6'h20, 32'hA1);
    do_wr(6'h20, 32'hA2);
    repeat (6) @(negedge clk);
    check("R11 held valid", {31'b0, tx_valid}, 32'd1);
    check("R11 held data", {24'b0, tx_data}, 32'hA1);
    do_wr(6'h14, 32'd1);
    do_wr(6'h10, 32'd1);
    do_wr(6'h20, 32'hEE);
    check("R11 still held", {24'b0, tx_data}, 32'hA1);
    set_ready(1'b1);
    repeat (20) @(negedge clk);
    check("R12 frame len", 32'(cap_n - base), 32'd2);
    check("R11 bp b1", {24'b0, cap_byte[base+1]}, 32'hA2);
    check("R11 bp last", {31'b0, cap_lastf[base+1]}, 32'd1);
    rd_check("R12 no txdone", 6'h14, 32'd0);
    rd_check("R12 count kept", 6'h10, 32'd1);

    // R11: full-buffer send with count 0
    do_wr(6'h10, 32'd0);
    base = cap_n;
    v = 32'(last_n);
    for (int i = 0; i < FMAX; i++) do_wr(6'h20, 32'((i * 7 + 3) & 8'hFF));
    for (int w = 0; w < 4000 && cap_n - base < FMAX; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R11 full len", 32'(cap_n - base), 32'd1514);
    check("R11 full one last", 32'(last_n) - v, 32'd1);
    check("R11 full last byte", {24'b0, cap_byte[base+FMAX-1]}, 32'((1513 * 7 + 3) & 8'hFF));
    check("R11 full last flag", {31'b0, cap_lastf[base+FMAX-1]}, 32'd1);
    rd_check("R11 full txdone", 6'h14, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule